// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a register-mapped general-purpose I/O controller for a parameterised number of pins. Registers are 32 bits wide and the pins are spread across them, 32 pins to a bank. Each pin has an output latch and a direction bit. Software never writes the latch directly. It changes the latch through one register that raises bits and another that lowers them, so a single write changes only the pins it names. A level register returns the synchronised state of every pad.

Each pin can watch for rising edges, falling edges, or both. A detected edge latches a sticky status bit. Software clears that bit by writing a one to it, and a single interrupt line is raised while any status bit is set. A 2-bit function field per pin decides what drives the pad: the GPIO logic, peripheral A, or peripheral B. A pin pair can therefore be swapped between two peripherals by rewriting their codes.

The register bus is a plain synchronous port. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`. The address is `{kind[3:0], index}`: `kind` names the register group and `index` selects the bank, or for the function group the function register.

Top module: `gpio_ctl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are all zero and `irq` is low. The block then behaves as all-GPIO inputs with no edge enabled.
- R2: A write to kind 2 (output raise) sets the output latch of every pin whose bit in that bank is 1. The latches of pins whose bit is 0 keep their value.
- R3: A write to kind 3 (output lower) clears the output latch of every pin whose bit is 1. The latches of pins whose bit is 0 keep their value.
- R4: Kinds 2 and 3 always read as zero.
- R5: Kind 0 (level) reads pin n at bit n mod 32 of bank n div 32. The value is `pad_in` passed through a two-stage synchroniser, so a pad change first shows on the read after the second rising clock edge. Bits of pins that do not exist read zero.
- R6: Kind 1 (direction) holds a read/write bit per pin, where 1 means output. A GPIO pin with direction 0 has `pad_oe` low, and bits of pins that do not exist read zero.
- R7: Kind 4 holds the rising-edge enables and kind 5 holds the falling-edge enables. An enabled edge sets the pin's status bit on the third rising clock edge after the pad changes. A pin with neither enable set never sets its status bit.
- R8: Kind 6 (edge status) reads the sticky status bits. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a new event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R9: `irq` is high exactly while at least one status bit is set.
- R10: In kind 7 (function), register r holds pin 16r+k in bits [2k+1:2k]. Code 0 selects the GPIO latch and direction bit. Code 1 selects `pa_out`/`pa_oe` and code 2 selects `pb_out`/`pb_oe`. Code 3 drives `pad_out` and `pad_oe` low. Bits of pins that do not exist read zero.
- R11: Exchanging the codes of two pins between 1 and 2 exchanges which peripheral drives each pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4+IDX_W | {kind, index} register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | NUM_PINS | Raw pad levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pa_out | input | NUM_PINS | Peripheral A output per pin |
| pa_oe | input | NUM_PINS | Peripheral A enable per pin |
| pb_out | input | NUM_PINS | Peripheral B output per pin |
| pb_oe | input | NUM_PINS | Peripheral B enable per pin |
| irq | output | 1 | OR of all edge status bits |

## Verification
The bench builds the block with 40 pins, so IDX_W is 2. The second bank is only partly populated, which brings the zero-reading bits 8 to 31 of bank 1 within reach. The third function register is half used, so its upper 16 bits must read zero. Peripheral A and B drive opposite bit patterns with opposite enables, so every function code and every swap leaves a distinct mark on `pad_out` and `pad_oe`. The edge tests time pad changes against the three-edge latency and land a clearing write on the same edge as a new event.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

    localparam int KIND_W = 4;
    localparam int FN_W   = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_LEVEL  = 4'd0,
        KIND_DIR    = 4'd1,
        KIND_RAISE  = 4'd2,
        KIND_LOWER  = 4'd3,
        KIND_RISE   = 4'd4,
        KIND_FALL   = 4'd5,
        KIND_STATUS = 4'd6,
        KIND_FUNC   = 4'd7
    } reg_kind_e;

    typedef enum logic [FN_W-1:0] {
        FN_GPIO = 2'd0,
        FN_PERA = 2'd1,
        FN_PERB = 2'd2,
        FN_OFF  = 2'd3
    } pin_fn_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;
    assign fall  = ~sync_q & prev_q;

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_ctl_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic [NUM_PINS-1:0][FN_W-1:0] func,
    input  logic [NUM_PINS-1:0]           gpio_out,
    input  logic [NUM_PINS-1:0]           gpio_oe,
    input  logic [NUM_PINS-1:0]           a_out,
    input  logic [NUM_PINS-1:0]           a_oe,
    input  logic [NUM_PINS-1:0]           b_out,
    input  logic [NUM_PINS-1:0]           b_oe,
    output logic [NUM_PINS-1:0]           pad_out,
    output logic [NUM_PINS-1:0]           pad_oe
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_comb begin
            unique case (pin_fn_e'(func[p]))
                FN_GPIO: begin pad_out[p] = gpio_out[p]; pad_oe[p] = gpio_oe[p]; end
                FN_PERA: begin pad_out[p] = a_out[p];    pad_oe[p] = a_oe[p];    end
                FN_PERB: begin pad_out[p] = b_out[p];    pad_oe[p] = b_oe[p];    end
                FN_OFF:  begin pad_out[p] = 1'b0;        pad_oe[p] = 1'b0;       end
            endcase
        end
    end

endmodule

// File: rtl/gpio_ctl.sv
module gpio_ctl
    import gpio_ctl_pkg::*;
#(
    parameter  int NUM_PINS = 40,
    localparam int BANKS    = (NUM_PINS + 31) / 32,
    localparam int FREGS    = (NUM_PINS + 15) / 16,
    localparam int NREG     = (FREGS > BANKS) ? FREGS : BANKS,
    localparam int IDX_W    = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int ADDR_W   = KIND_W + IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    input  logic [NUM_PINS-1:0] pa_out,
    input  logic [NUM_PINS-1:0] pa_oe,
    input  logic [NUM_PINS-1:0] pb_out,
    input  logic [NUM_PINS-1:0] pb_oe,
    output logic                irq
);

    reg_kind_e          kind;
    logic [IDX_W-1:0]   idx;

    logic [NUM_PINS-1:0] bank_hit;
    logic [NUM_PINS-1:0] lane_bit;
    logic [NUM_PINS-1:0] lane_mask;
    logic [NUM_PINS-1:0] fn_hit;
    logic [NUM_PINS-1:0][FN_W-1:0] fn_lane;

    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] out_q;
    logic [NUM_PINS-1:0] rise_en_q;
    logic [NUM_PINS-1:0] fall_en_q;
    logic [NUM_PINS-1:0] status_q;
    logic [NUM_PINS-1:0][FN_W-1:0] func_q;

    logic [NUM_PINS-1:0] level;
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] fall;
    logic [NUM_PINS-1:0] evt;
    logic [NUM_PINS-1:0] banked_src;

    logic wr_dir, wr_raise, wr_lower, wr_rise, wr_fall, wr_status, wr_func;

    assign kind = reg_kind_e'(bus_addr[ADDR_W-1 -: KIND_W]);
    assign idx  = bus_addr[IDX_W-1:0];

    // Per-pin view of the addressed register: lane select and write bit.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
        assign bank_hit[p] = (32'(idx) == 32'(p / 32));
        assign lane_bit[p] = bus_wdata[p % 32];
        assign fn_hit[p]   = (32'(idx) == 32'(p / 16));
        assign fn_lane[p]  = bus_wdata[FN_W*(p % 16) +: FN_W];
    end

    assign lane_mask = bank_hit & lane_bit;

    assign wr_dir    = bus_wr && (kind == KIND_DIR);
    assign wr_raise  = bus_wr && (kind == KIND_RAISE);
    assign wr_lower  = bus_wr && (kind == KIND_LOWER);
    assign wr_rise   = bus_wr && (kind == KIND_RISE);
    assign wr_fall   = bus_wr && (kind == KIND_FALL);
    assign wr_status = bus_wr && (kind == KIND_STATUS);
    assign wr_func   = bus_wr && (kind == KIND_FUNC);

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pad_in),
        .level (level),
        .rise  (rise),
        .fall  (fall)
    );

    assign evt = (rise & rise_en_q) | (fall & fall_en_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q     <= '0;
            out_q     <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
            status_q  <= '0;
        end else begin
            if (wr_dir)   dir_q     <= (dir_q     & ~bank_hit) | lane_mask;
            if (wr_rise)  rise_en_q <= (rise_en_q & ~bank_hit) | lane_mask;
            if (wr_fall)  fall_en_q <= (fall_en_q & ~bank_hit) | lane_mask;
            if (wr_raise) out_q     <= out_q | lane_mask;
            if (wr_lower) out_q     <= out_q & ~lane_mask;
            // New events take priority over a same-cycle clear.
            status_q <= (status_q & ~(wr_status ? lane_mask : '0)) | evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            func_q <= '0;
        end else if (wr_func) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (fn_hit[p]) func_q[p] <= fn_lane[p];
            end
        end
    end

    always_comb begin
        case (kind)
            KIND_LEVEL:  banked_src = level;
            KIND_DIR:    banked_src = dir_q;
            KIND_RISE:   banked_src = rise_en_q;
            KIND_FALL:   banked_src = fall_en_q;
            KIND_STATUS: banked_src = status_q;
            default:     banked_src = '0;
        endcase
    end

    always_comb begin
        bus_rdata = '0;
        if (kind == KIND_FUNC) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (fn_hit[p]) bus_rdata[FN_W*(p % 16) +: FN_W] = func_q[p];
            end
        end else begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (bank_hit[p]) bus_rdata[p % 32] = banked_src[p];
            end
        end
    end

    gpio_pad_mux #(.NUM_PINS(NUM_PINS)) u_mux (
        .func     (func_q),
        .gpio_out (out_q),
        .gpio_oe  (dir_q),
        .a_out    (pa_out),
        .a_oe     (pa_oe),
        .b_out    (pb_out),
        .b_oe     (pb_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    assign irq = |status_q;

endmodule

// File: rtl/gpio_ctl_chk.sv
module gpio_ctl_chk
    import gpio_ctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              out0,
    input logic              stat0,
    input logic              evt0,
    input logic              rise0,
    input logic              fall0,
    input logic              irq
);

    logic [KIND_W-1:0] kind;
    logic              idx0;
    logic              hit0;

    assign kind = bus_addr[ADDR_W-1 -: KIND_W];
    assign idx0 = (bus_addr[ADDR_W-KIND_W-1:0] == '0);
    assign hit0 = bus_wr && idx0 && bus_wdata[0];

    // R2
    raise_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit0 && kind == KIND_RAISE) |=> out0);

    // R3
    lower_clears_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit0 && kind == KIND_LOWER) |=> !out0);

    // R7
    no_status_without_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat0) |-> $past(rise0 || fall0));

    // R8
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0 && !(hit0 && kind == KIND_STATUS)) |=> stat0);

    // R8
    event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt0 |=> stat0);

    // R9
    irq_drops_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr && kind == KIND_STATUS));

endmodule

bind gpio_ctl gpio_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .out0      (out_q[0]),
    .stat0     (status_q[0]),
    .evt0      (evt[0]),
    .rise0     (rise_en_q[0]),
    .fall0     (fall_en_q[0]),
    .irq       (irq)
);

// File: tb/gpio_ctl_test.sv
module gpio_ctl_test;

    localparam int N = 40;
    localparam int AW = 6;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_PO = 2'd2;
    localparam logic [1:0] OP_OE = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  kind;
        logic [1:0]  idx;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{OP_WR, 4'd1, 2'd0, 32'h0000_00FF, 4'd6},
        '{OP_RD, 4'd1, 2'd0, 32'h0000_00FF, 4'd6},  // R6
        '{OP_OE, 4'd0, 2'd0, 32'h0000_00FF, 4'd6},  // R6
        '{OP_WR, 4'd2, 2'd0, 32'h0000_00F0, 4'd2},
        '{OP_PO, 4'd0, 2'd0, 32'h0000_00F0, 4'd2},  // R2
        '{OP_WR, 4'd2, 2'd0, 32'h0000_000F, 4'd2},
        '{OP_PO, 4'd0, 2'd0, 32'h0000_00FF, 4'd2},  // R2
        '{OP_WR, 4'd3, 2'd0, 32'h0000_003C, 4'd3},
        '{OP_PO, 4'd0, 2'd0, 32'h0000_00C3, 4'd3},  // R3
        '{OP_RD, 4'd2, 2'd0, 32'h0000_0000, 4'd4},  // R4
        '{OP_RD, 4'd3, 2'd0, 32'h0000_0000, 4'd4},  // R4
        '{OP_WR, 4'd1, 2'd1, 32'hFFFF_FFFF, 4'd6},
        '{OP_RD, 4'd1, 2'd1, 32'h0000_00FF, 4'd6},  // R6
        '{OP_WR, 4'd1, 2'd1, 32'h0000_0000, 4'd6},
        '{OP_WR, 4'd7, 2'd0, 32'h0000_0600, 4'd10},
        '{OP_RD, 4'd7, 2'd0, 32'h0000_0600, 4'd10}, // R10
        '{OP_PO, 4'd0, 2'd0, 32'h0000_00F3, 4'd10}, // R10
        '{OP_OE, 4'd0, 2'd0, 32'h0000_00DF, 4'd10}, // R10
        '{OP_WR, 4'd7, 2'd0, 32'h0000_0900, 4'd11},
        '{OP_PO, 4'd0, 2'd0, 32'h0000_00C3, 4'd11}, // R11
        '{OP_OE, 4'd0, 2'd0, 32'h0000_00EF, 4'd11}, // R11
        '{OP_WR, 4'd7, 2'd0, 32'h0000_3000, 4'd10},
        '{OP_PO, 4'd0, 2'd0, 32'h0000_0083, 4'd10}, // R10
        '{OP_OE, 4'd0, 2'd0, 32'h0000_00BF, 4'd10}, // R10
        '{OP_WR, 4'd7, 2'd2, 32'hFFFF_FFFF, 4'd10},
        '{OP_RD, 4'd7, 2'd2, 32'h0000_FFFF, 4'd10}, // R10
        '{OP_WR, 4'd7, 2'd2, 32'h0000_0000, 4'd10},
        '{OP_WR, 4'd7, 2'd0, 32'h0000_0000, 4'd10},
        '{OP_PO, 4'd0, 2'd0, 32'h0000_00C3, 4'd3}   // R3
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe;
    logic [N-1:0]  pa_out = 40'hAA_AAAA_AAAA;
    logic [N-1:0]  pa_oe  = '0;
    logic [N-1:0]  pb_out = 40'h55_5555_5555;
    logic [N-1:0]  pb_oe  = '1;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] v;

    always #10 clk = ~clk;

    gpio_ctl #(.NUM_PINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_out(pb_out), .pb_oe(pb_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] k, input logic [1:0] i, input logic [31:0] d);
        @(negedge clk);
        bus_addr = {k, i}; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] k, input logic [1:0] i, output logic [31:0] d);
        bus_addr = {k, i};
        #1 d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20ns * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        for (int k = 0; k < 8; k++) begin
            rd(4'(k), 2'd0, v); chk("R1", v, 32'h0);
        end
        chk("R1", {24'h0, pad_oe[7:0]}, 32'h0);
        chk("R1", {31'h0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_WR: wr(VECS[i].kind, VECS[i].idx, VECS[i].data);
                OP_RD: begin
                    rd(VECS[i].kind, VECS[i].idx, v);
                    chk($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].data);
                end
                OP_PO: begin #1 chk($sformatf("R%0d vec%0d", VECS[i].req, i), pad_out[31:0], VECS[i].data); end
                default: begin #1 chk($sformatf("R%0d vec%0d", VECS[i].req, i), pad_oe[31:0], VECS[i].data); end
            endcase
        end

        // R5 level timing and bank placement
        @(negedge clk);
        pad_in[39:32] = 8'hA5; pad_in[20] = 1'b1;
        @(negedge clk);
        rd(4'd0, 2'd1, v); chk("R5 early", v, 32'h0);
        @(negedge clk);
        rd(4'd0, 2'd1, v); chk("R5 bank1", v, 32'h0000_00A5);
        rd(4'd0, 2'd0, v); chk("R5 bank0", v, 32'h0010_0000);

        // R7 rising edge on pin 8
        wr(4'd4, 2'd0, 32'h0000_0100);
        wr(4'd5, 2'd0, 32'h0000_0200);
        @(negedge clk); pad_in[8] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(4'd6, 2'd0, v); chk("R7 latency", v, 32'h0);
        @(negedge clk);
        rd(4'd6, 2'd0, v); chk("R7 rise", v, 32'h0000_0100);
        chk("R9 irq set", {31'h0, irq}, 32'h1);

        // R7 disabled directions and pins raise nothing
        @(negedge clk); pad_in[8] = 1'b0; pad_in[10] = 1'b1;
        wait_n(4);
        rd(4'd6, 2'd0, v); chk("R7 no event", v, 32'h0000_0100);

        // R8 write-zero no effect, write-one clears
        wr(4'd6, 2'd0, 32'h0);
        rd(4'd6, 2'd0, v); chk("R8 zero", v, 32'h0000_0100);
        wr(4'd6, 2'd0, 32'h0000_0100);
        rd(4'd6, 2'd0, v); chk("R8 clear", v, 32'h0);
        chk("R9 irq clear", {31'h0, irq}, 32'h0);

        // R7 falling edge on pin 9
        @(negedge clk); pad_in[9] = 1'b1;
        wait_n(4);
        rd(4'd6, 2'd0, v); chk("R7 fall only", v, 32'h0);
        pad_in[9] = 1'b0;
        wait_n(4);
        rd(4'd6, 2'd0, v); chk("R7 fall", v, 32'h0000_0200);
        wr(4'd6, 2'd0, 32'h0000_0200);

        // R8 event and clear on the same edge
        @(negedge clk); pad_in[8] = 1'b1;
        wait_n(4);
        pad_in[8] = 1'b0;
        wait_n(4);
        rd(4'd6, 2'd0, v); chk("R8 preset", v, 32'h0000_0100);
        pad_in[8] = 1'b1;
        @(negedge clk);
        wr(4'd6, 2'd0, 32'h0000_0100);
        rd(4'd6, 2'd0, v); chk("R8 event wins", v, 32'h0000_0100);
        wr(4'd6, 2'd0, 32'h0000_0100);
        rd(4'd6, 2'd0, v); chk("R8 final clear", v, 32'h0);
        chk("R9 irq low", {31'h0, irq}, 32'h0);

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule